// File: doc/BRIEF.md
# RMII Receive Di-bit Formatter

This block sits at the receive edge of a PHY. Upstream logic hands it decoded nibbles through a write strobe, together with an internal carrier-sense flag. The block places those nibbles on a two-bit receive bus, one di-bit per cycle of the single 50 MHz reference clock. It drives no receive clock of its own. A small elastic FIFO sits between the nibble writer and the di-bit sequencer. It absorbs the rate mismatch between the recovered data and the reference clock. In this model the crossing is reduced to a synchronous write strobe.

Carrier sense and data valid share one output, `crs_dv`. After carrier falls while the FIFO still holds data, `crs_dv` is low on the first di-bit of each nibble and high on the second. This tells a MAC both that carrier has ended and where the data ends. Output of a frame is held back until the FIFO reaches a start level, so that the buffer has slack when the writer runs either faster or slower than the reader. Overflow and underflow each set a sticky flag.

The sequencer has four states:
- `ST_IDLE` means no frame.
- `ST_FILL` means carrier is seen but output is waiting for data.
- `ST_LO` presents bits [1:0] of the head nibble.
- `ST_HI` presents bits [3:2] of the head nibble and pops it.

The transitions are:
- IDLE→FILL when carrier rises.
- FILL→LO when the level reaches `START_LEVEL`, or when carrier is low and data is buffered.
- FILL→IDLE when carrier is low and the FIFO is empty.
- LO→HI always.
- HI→LO when another nibble is available, counting a write in the same cycle.
- HI→FILL when none is available and carrier is high. This transition also records an underflow.
- HI→IDLE when none is available and carrier is low.

Top module: `rmii_rx_dibit_fmt`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the FIFO, the sequencer phase and both flags clear, so afterwards `rxd`=00, `crs_dv`=0, `ovf_err`=0 and `unf_err`=0.
- R2: With carrier high, no di-bit is presented until the FIFO holds at least `START_LEVEL` nibbles (default 8 of 16). Meanwhile `rxd`=00 and `crs_dv` equals carrier. The sequencer sees the level one cycle after the write that reaches it.
- R3: Each nibble occupies two consecutive cycles on `rxd`: bits [1:0] first, then bits [3:2]. Nibbles leave in write order.
- R4: While carrier is high and a nibble is being presented, `crs_dv` is 1 on both di-bits.
- R5: With carrier low and buffered data still being sent, `crs_dv` is 0 on the first di-bit of each nibble and 1 on the second.
- R6: Once the last buffered nibble has been sent and carrier is low, `rxd`=00 and `crs_dv`=0.
- R7: If carrier falls before `START_LEVEL` is reached, the nibbles already buffered are still sent, using the R5 pattern.
- R8: A write strobe while the FIFO holds `DEPTH` nibbles sets `ovf_err`. That write and every later write are discarded until carrier is seen low.
- R9: If the FIFO is empty at a nibble boundary while carrier is high, `unf_err` is set. The block then holds `rxd`=00 with `crs_dv`=1 and waits for the start level again.
- R10: `ovf_err` and `unf_err` are sticky and clear only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock for the whole block |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_wr | input | 1 | Write strobe for one received nibble |
| nib_data | input | 4 | Received nibble |
| carrier_in | input | 1 | Internal carrier-sense flag |
| rxd | output | 2 | Receive di-bit bus |
| crs_dv | output | 1 | Merged carrier-sense / data-valid |
| ovf_err | output | 1 | Sticky FIFO overflow flag |
| unf_err | output | 1 | Sticky FIFO underflow flag |

## Verification
The bench targets four corner cases:
- **Carrier falls while data is buffered.** The bench checks the drain at every cycle. A design that dropped `crs_dv` permanently at the end of carrier would lose the tail of the frame. One that kept it high would hide the carrier edge.
- **Carrier falls before the start level.** A design that only drained after reaching the threshold would hang in `ST_FILL` with data stuck in the buffer.
- **Overflow.** The bench fills the FIFO at exactly the cycle where the level hits `DEPTH`, then keeps writing a different nibble value. Any of those late writes that reached the bus would show up as a di-bit pattern that never otherwise appears.
- **Underflow.** A design that stalled, or that dropped `crs_dv` on a mid-frame underflow, would be caught by a check in the exact cycle the flag must appear.

// File: rtl/rmii_rx_pkg.sv
`timescale 1ns/1ps
package rmii_rx_pkg;

    localparam int NIB_W   = 4;
    localparam int DIBIT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_LO   = 2'd2,
        ST_HI   = 2'd3
    } rx_state_t;

endpackage

// File: rtl/rmii_rx_nib_fifo.sv
`timescale 1ns/1ps
module rmii_rx_nib_fifo
    import rmii_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [NIB_W-1:0] din,
    input  logic             pop,
    output logic [NIB_W-1:0] head,
    output logic [LW-1:0]    level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [NIB_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    // storage has no reset; occupancy is tracked by the level counter
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/rmii_rx_wr_guard.sv
`timescale 1ns/1ps
module rmii_rx_wr_guard #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          carrier,
    input  logic [LW-1:0] level,
    output logic          push,
    output logic          ovf_err
);
    logic full;
    logic drop_q;

    assign full = (level == LW'(DEPTH));
    assign push = wr_en && !full && !drop_q;

    // once a write hits a full buffer, the rest of the frame is discarded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q  <= 1'b0;
            ovf_err <= 1'b0;
        end else begin
            if (!carrier) begin
                drop_q <= 1'b0;
            end else if (wr_en && full) begin
                drop_q <= 1'b1;
            end
            if (wr_en && full) begin
                ovf_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rmii_rx_seq.sv
`timescale 1ns/1ps
module rmii_rx_seq
    import rmii_rx_pkg::*;
#(
    parameter int START_LEVEL = 8,
    parameter int LW          = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               carrier,
    input  logic [LW-1:0]      level,
    input  logic               push,
    input  logic [NIB_W-1:0]   head,
    output rx_state_t          st,
    output logic               pop,
    output logic [DIBIT_W-1:0] rxd,
    output logic               crs_dv,
    output logic               unf_err
);
    localparam logic [LW-1:0] START = LW'(START_LEVEL);
    localparam logic [LW-1:0] ONE   = LW'(1);

    rx_state_t st_nxt;
    logic      more;
    logic      starve;

    // another nibble is ready after the current pop (a same-cycle write counts)
    assign more   = (level > ONE) || push;
    assign starve = (st == ST_HI) && !more && carrier;
    assign pop    = (st == ST_HI);

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (carrier) st_nxt = ST_FILL;
            end
            ST_FILL: begin
                if (level >= START)        st_nxt = ST_LO;
                else if (!carrier) begin
                    if (level != '0)       st_nxt = ST_LO;
                    else                   st_nxt = ST_IDLE;
                end
            end
            ST_LO: begin
                st_nxt = ST_HI;
            end
            ST_HI: begin
                if (more)                  st_nxt = ST_LO;
                else if (carrier)          st_nxt = ST_FILL;
                else                       st_nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            unf_err <= 1'b0;
        end else begin
            st <= st_nxt;
            if (starve) begin
                unf_err <= 1'b1;
            end
        end
    end

    always_comb begin
        rxd    = '0;
        crs_dv = 1'b0;
        unique case (st)
            ST_IDLE: begin
                rxd    = '0;
                crs_dv = 1'b0;
            end
            ST_FILL: begin
                rxd    = '0;
                crs_dv = carrier;
            end
            ST_LO: begin
                rxd    = head[1:0];
                crs_dv = carrier;
            end
            ST_HI: begin
                rxd    = head[3:2];
                crs_dv = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rmii_rx_dibit_fmt.sv
`timescale 1ns/1ps
module rmii_rx_dibit_fmt
    import rmii_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int START_LEVEL = DEPTH / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nib_wr,
    input  logic [NIB_W-1:0]   nib_data,
    input  logic               carrier_in,
    output logic [DIBIT_W-1:0] rxd,
    output logic               crs_dv,
    output logic               ovf_err,
    output logic               unf_err
);
    localparam int LW = $clog2(DEPTH + 1);

    logic             push;
    logic             pop;
    logic [LW-1:0]    level;
    logic [NIB_W-1:0] head;
    rx_state_t        st;

    rmii_rx_wr_guard #(
        .DEPTH (DEPTH),
        .LW    (LW)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (nib_wr),
        .carrier (carrier_in),
        .level   (level),
        .push    (push),
        .ovf_err (ovf_err)
    );

    rmii_rx_nib_fifo #(
        .DEPTH (DEPTH),
        .LW    (LW)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (nib_data),
        .pop   (pop),
        .head  (head),
        .level (level)
    );

    rmii_rx_seq #(
        .START_LEVEL (START_LEVEL),
        .LW          (LW)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .carrier (carrier_in),
        .level   (level),
        .push    (push),
        .head    (head),
        .st      (st),
        .pop     (pop),
        .rxd     (rxd),
        .crs_dv  (crs_dv),
        .unf_err (unf_err)
    );

endmodule

// File: rtl/rmii_rx_chk.sv
`timescale 1ns/1ps
module rmii_rx_chk
    import rmii_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               carrier_in,
    input  logic               nib_wr,
    input  logic [DIBIT_W-1:0] rxd,
    input  logic               crs_dv,
    input  logic               ovf_err,
    input  logic               unf_err,
    input  rx_state_t          st,
    input  logic [LW-1:0]      level
);
    // R1: a reset cycle leaves the flags clear
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!ovf_err && !unf_err));

    // R2: while waiting for the start level the bus is quiet
    p_fill_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |-> (rxd == 2'b00 && crs_dv == carrier_in));

    // R3: the low di-bit is always followed by the high di-bit
    p_lo_then_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LO) |=> (st == ST_HI));

    // R5: the second di-bit of a nibble is always flagged valid
    p_hi_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HI) |-> crs_dv);

    // R6: idle means a silent bus
    p_idle_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (rxd == 2'b00 && !crs_dv));

    // R8: occupancy never exceeds the depth
    p_no_overfill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R8: a write into a full buffer raises the overflow flag
    p_full_write_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_wr && level == LW'(DEPTH)) |=> ovf_err);

    // R10: both flags are sticky
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
    p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err |=> unf_err);

endmodule

bind rmii_rx_dibit_fmt rmii_rx_chk #(
    .DEPTH (DEPTH),
    .LW    (LW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier_in (carrier_in),
    .nib_wr     (nib_wr),
    .rxd        (rxd),
    .crs_dv     (crs_dv),
    .ovf_err    (ovf_err),
    .unf_err    (unf_err),
    .st         (st),
    .level      (level)
);

// File: tb/test_rmii_rx_dibit_fmt.sv
`timescale 1ns/1ps
module test_rmii_rx_dibit_fmt;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       nib_wr;
    logic [3:0] nib_data;
    logic       carrier;
    logic [1:0] rxd;
    logic       crs_dv;
    logic       ovf_err;
    logic       unf_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rmii_rx_dibit_fmt i_rmii_rx_dibit_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .nib_wr     (nib_wr),
        .nib_data   (nib_data),
        .carrier_in (carrier),
        .rxd        (rxd),
        .crs_dv     (crs_dv),
        .ovf_err    (ovf_err),
        .unf_err    (unf_err)
    );

    // {carrier, write, nibble[3:0], expected rxd[1:0], expected crs_dv}
    localparam logic [8:0] VEC [36] = '{
        9'b1_1_1001_00_1, 9'b1_1_0110_00_1, 9'b1_1_1100_00_1, 9'b1_1_0011_00_1,
        9'b1_1_1010_00_1, 9'b1_1_0101_00_1, 9'b1_1_1111_00_1, 9'b1_1_0000_00_1,
        9'b1_0_0000_01_1, 9'b1_0_0000_10_1, 9'b1_0_0000_10_1, 9'b1_0_0000_01_1,
        9'b0_0_0000_00_0, 9'b0_0_0000_11_1, 9'b0_0_0000_11_0, 9'b0_0_0000_00_1,
        9'b0_0_0000_10_0, 9'b0_0_0000_10_1, 9'b0_0_0000_01_0, 9'b0_0_0000_01_1,
        9'b0_0_0000_11_0, 9'b0_0_0000_11_1, 9'b0_0_0000_00_0, 9'b0_0_0000_00_1,
        9'b0_0_0000_00_0, 9'b0_0_0000_00_0, 9'b1_1_1101_00_1, 9'b1_1_0010_00_1,
        9'b1_1_0111_00_1, 9'b0_0_0000_01_0, 9'b0_0_0000_11_1, 9'b0_0_0000_10_0,
        9'b0_0_0000_00_1, 9'b0_0_0000_11_0, 9'b0_0_0000_01_1, 9'b0_0_0000_00_0
    };

    function automatic string row_tag(int r);
        if (r <= 8)  return "R2 fill wait";
        if (r <= 12) return "R3/R4 carrier-on di-bits";
        if (r <= 24) return "R5 drain toggling";
        if (r <= 26) return "R6 idle after drain";
        if (r <= 29) return "R2 fill of short frame";
        if (r <= 35) return "R7 early carrier loss";
        return "R6 idle after short frame";
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(logic c, logic w, logic [3:0] n);
        @(negedge clk);
        carrier  = c;
        nib_wr   = w;
        nib_data = n;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        carrier  = 1'b0;
        nib_wr   = 1'b0;
        nib_data = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset bus", {6'd0, rxd}, 8'd0);
        chk("R1 reset crs_dv", {7'd0, crs_dv}, 8'd0);
        chk("R1 R10 reset flags", {6'd0, ovf_err, unf_err}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt01;
        int cnt10;
        rst_n    = 1'b0;
        carrier  = 1'b0;
        nib_wr   = 1'b0;
        nib_data = '0;
        do_reset();

        // cycle table: full frame with drain, then short frame ended early
        for (int i = 0; i < 36; i++) begin
            drive(VEC[i][8], VEC[i][7], VEC[i][6:3]);
            chk(row_tag(i + 1), {5'd0, rxd, crs_dv}, {5'd0, VEC[i][2:0]});
        end
        chk("R8 no spurious overflow", {7'd0, ovf_err}, 8'd0);
        chk("R9 no spurious underflow", {7'd0, unf_err}, 8'd0);

        // R8: overflow at the exact cycle, then later writes dropped
        do_reset();
        cnt01 = 0;
        cnt10 = 0;
        for (int i = 1; i <= 30; i++) begin
            drive(1'b1, 1'b1, (i <= 22) ? 4'h5 : 4'hA);
            if (rxd == 2'b01) cnt01++;
            if (rxd == 2'b10) cnt10++;
            if (i == 22) chk("R8 flag before full write", {7'd0, ovf_err}, 8'd0);
            if (i == 23) chk("R8 flag on full write", {7'd0, ovf_err}, 8'd1);
        end
        for (int i = 0; i < 60; i++) begin
            drive(1'b0, 1'b0, 4'h0);
            if (rxd == 2'b01) cnt01++;
            if (rxd == 2'b10) cnt10++;
        end
        chk("R8 accepted di-bits", 8'(cnt01), 8'd44);
        chk("R8 dropped writes never sent", 8'(cnt10), 8'd0);
        chk("R6 idle after overflow drain", {5'd0, rxd, crs_dv}, 8'd0);
        chk("R10 overflow sticky", {7'd0, ovf_err}, 8'd1);

        // R9: underflow mid-frame with carrier still high
        do_reset();
        for (int i = 1; i <= 8; i++) drive(1'b1, 1'b1, 4'h3);
        for (int i = 9; i <= 25; i++) begin
            drive(1'b1, 1'b0, 4'h0);
            if (i == 24) begin
                chk("R9 no flag before boundary", {7'd0, unf_err}, 8'd0);
                chk("R3 last high di-bit", {5'd0, rxd, crs_dv}, 8'b001);
            end
            if (i == 25) begin
                chk("R9 underflow flag", {7'd0, unf_err}, 8'd1);
                chk("R9 wait with crs_dv high", {5'd0, rxd, crs_dv}, 8'b001);
            end
        end
        drive(1'b0, 1'b0, 4'h0);
        chk("R6 idle after underflow", {5'd0, rxd, crs_dv}, 8'd0);
        chk("R10 underflow sticky", {7'd0, unf_err}, 8'd1);

        // R10: only reset clears the flags
        do_reset();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule